// File: doc/BRIEF.md
# Scaled Index Effective Address Unit

This block computes the memory address of an operand from a base register value, an index register value scaled by a power of two, and an optional signed displacement taken from the instruction bytes. It sits after the register file read port of an address stage. Decode logic supplies the values already read for the selected base and index registers. It also supplies the index selector field, a 2-bit scale shift code, a displacement length code with the raw displacement bytes, and the current mode together with an address-size override flag.

The address size is resolved first. The sum is then formed modulo that size. The upper output bits are forced to zero. The result is registered, and it appears one clock after the input strobe together with a matching valid output.

A two-state machine tracks the output qualifier. The states are ST_IDLE (no address presented) and ST_EMIT (out_addr holds a fresh address). The transitions are as follows:
- ST_IDLE to ST_EMIT and ST_EMIT to ST_EMIT on an in_valid cycle.
- ST_EMIT to ST_IDLE and ST_IDLE to ST_IDLE on a cycle without in_valid.

Top module: `scaled_ea_unit`

## Requirements
- R1: While rst_n is low, and after its release until the first strobe, out_valid is 0 and out_addr is 0.
- R2: out_valid is 1 in exactly the cycle after each cycle in which in_valid is 1, and 0 after each cycle in which in_valid is 0. Back-to-back strobes give back-to-back results.
- R3: On a cycle with in_valid low, out_addr keeps its last value, whatever the other inputs carry.
- R4: The address is base_val + (index_val << scale_code) + displacement. Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R5: disp_size sets the displacement. Code 0 means none (zero). Code 1 uses disp_raw[7:0], sign-extended. Code 2 uses disp_raw[31:0], sign-extended. Code 3 is treated as none.
- R6: When index_sel equals 4 (the stack pointer encoding), no index is used and the index term is zero, whatever index_val holds.
- R7: The address size is set by mode_code and size_ovr. Mode code 0 gives 16 bits, code 1 gives 32 bits, and codes 2 and 3 give 64 bits. With size_ovr set, 64 becomes 32, 32 becomes 16, and 16 becomes 32.
- R8: Only the low bits of base_val and index_val within the active address size affect the result. Bits above it are ignored.
- R9: The sum wraps modulo 2^size. Carries out of the top bit are dropped, and out_addr bits at and above the active size are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: inputs hold an address request this cycle |
| base_val | input | 64 | Value read for the base register |
| index_val | input | 64 | Value read for the index register |
| index_sel | input | 4 | Index register selector; 4 means no index |
| scale_code | input | 2 | Index left-shift count |
| disp_size | input | 2 | Displacement length code |
| disp_raw | input | 32 | Raw displacement bytes, little end in bit 0 |
| mode_code | input | 2 | Current mode code selecting the default address size |
| size_ovr | input | 1 | Address-size override flag |
| out_valid | output | 1 | out_addr carries a new address |
| out_addr | output | 64 | Effective address, zero above the active size |

## Verification
Directed patterns each isolate one term of the sum:
- Every scale code applied to the same index separates the four shift amounts.
- Negative byte and word displacements separate sign extension from zero extension.
- An index value with a large index and selector 4 tells the no-index rule apart from an ordinary register.
- Junk in the upper operand bits, combined with every mode and override pairing, shows that size resolution and truncation act together. A 16-bit sum that carries past bit 15 confirms the wrap.

Seeded random requests, issued back to back, mix all fields against a bench model. Idle cycles with changed inputs show that the held address and the valid timing are independent of the data inputs.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [1:0] {
        ASZ16 = 2'd0,
        ASZ32 = 2'd1,
        ASZ64 = 2'd2
    } asz_e;

    typedef enum logic [1:0] {
        DSP_NONE = 2'd0,
        DSP_BYTE = 2'd1,
        DSP_WORD = 2'd2,
        DSP_RSVD = 2'd3
    } disp_e;

    typedef enum logic [1:0] {
        MODE_16 = 2'd0,
        MODE_32 = 2'd1,
        MODE_64 = 2'd2,
        MODE_RS = 2'd3
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;

endpackage

// File: rtl/ea_size_sel.sv
module ea_size_sel
    import ea_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [1:0]        mode_code,
    input  logic              size_ovr,
    output logic [ADDR_W-1:0] size_mask
);

    localparam int W16 = (ADDR_W < 16) ? ADDR_W : 16;
    localparam int W32 = (ADDR_W < 32) ? ADDR_W : 32;

    asz_e eff_size;
    int   width_bits;

    always_comb begin
        unique case (mode_e'(mode_code))
            MODE_16: eff_size = size_ovr ? ASZ32 : ASZ16;
            MODE_32: eff_size = size_ovr ? ASZ16 : ASZ32;
            MODE_64,
            MODE_RS: eff_size = size_ovr ? ASZ32 : ASZ64;
            default: eff_size = ASZ64;
        endcase
    end

    always_comb begin
        unique case (eff_size)
            ASZ16:   width_bits = W16;
            ASZ32:   width_bits = W32;
            default: width_bits = ADDR_W;
        endcase
    end

    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            size_mask[i] = (i < width_bits);
        end
    end

endmodule

// File: rtl/ea_disp_ext.sv
module ea_disp_ext
    import ea_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 32
) (
    input  logic [1:0]        disp_size,
    input  logic [DISP_W-1:0] disp_raw,
    output logic [ADDR_W-1:0] disp_ext
);

    localparam int BYTE_W = 8;

    always_comb begin
        unique case (disp_e'(disp_size))
            DSP_BYTE: disp_ext = {{(ADDR_W-BYTE_W){disp_raw[BYTE_W-1]}}, disp_raw[BYTE_W-1:0]};
            DSP_WORD: disp_ext = {{(ADDR_W-DISP_W){disp_raw[DISP_W-1]}}, disp_raw};
            DSP_NONE,
            DSP_RSVD: disp_ext = '0;
            default:  disp_ext = '0;
        endcase
    end

endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
    parameter int ADDR_W  = 64,
    parameter int SCALE_W = 2
) (
    input  logic [ADDR_W-1:0]  base_val,
    input  logic [ADDR_W-1:0]  index_val,
    input  logic               no_index,
    input  logic [SCALE_W-1:0] scale_code,
    input  logic [ADDR_W-1:0]  disp_ext,
    input  logic [ADDR_W-1:0]  size_mask,
    output logic [ADDR_W-1:0]  ea
);

    logic [ADDR_W-1:0] idx_term;
    logic [ADDR_W-1:0] raw_sum;

    always_comb begin
        idx_term = no_index ? '0 : (index_val << scale_code);
        raw_sum  = base_val + idx_term + disp_ext;
        ea       = raw_sum & size_mask;
    end

endmodule

// File: rtl/scaled_ea_unit.sv
module scaled_ea_unit
    import ea_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int DISP_W    = 32,
    parameter int SEL_W     = 4,
    parameter int SCALE_W   = 2,
    parameter int NOIDX_SEL = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic [ADDR_W-1:0]  index_val,
    input  logic [SEL_W-1:0]   index_sel,
    input  logic [SCALE_W-1:0] scale_code,
    input  logic [1:0]         disp_size,
    input  logic [DISP_W-1:0]  disp_raw,
    input  logic [1:0]         mode_code,
    input  logic               size_ovr,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr
);

    localparam logic [SEL_W-1:0] NOIDX_CODE = SEL_W'(NOIDX_SEL);

    state_e            state_q;
    state_e            state_d;
    logic [ADDR_W-1:0] size_mask;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] ea_next;
    logic [ADDR_W-1:0] addr_q;

    ea_size_sel #(.ADDR_W(ADDR_W)) size_i (
        .mode_code (mode_code),
        .size_ovr  (size_ovr),
        .size_mask (size_mask)
    );

    ea_disp_ext #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) disp_i (
        .disp_size (disp_size),
        .disp_raw  (disp_raw),
        .disp_ext  (disp_ext)
    );

    ea_sum #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) sum_i (
        .base_val   (base_val),
        .index_val  (index_val),
        .no_index   (index_sel == NOIDX_CODE),
        .scale_code (scale_code),
        .disp_ext   (disp_ext),
        .size_mask  (size_mask),
        .ea         (ea_next)
    );

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // address register, loaded only on a strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        addr_q <= '0;
        else if (in_valid) addr_q <= ea_next;
    end

    // outputs
    always_comb begin
        out_valid = (state_q == ST_EMIT);
        out_addr  = addr_q;
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_addr));

    // R9
    trunc16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((mode_code == 2'd0 && !size_ovr) || (mode_code == 2'd1 && size_ovr)))
        |=> (out_addr[ADDR_W-1:16] == '0));

    // R9
    trunc32_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((mode_code == 2'd1 && !size_ovr) || (mode_code != 2'd1 && size_ovr)))
        |=> (out_addr[ADDR_W-1:32] == '0));

    // R6
    no_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && index_sel == NOIDX_CODE && disp_size == 2'd0
         && mode_code == 2'd2 && !size_ovr)
        |=> (out_addr == $past(base_val)));

endmodule

// File: tb/scaled_ea_unit_tb_top.sv
module scaled_ea_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] base_val;
    logic [63:0] index_val;
    logic [3:0]  index_sel;
    logic [1:0]  scale_code;
    logic [1:0]  disp_size;
    logic [31:0] disp_raw;
    logic [1:0]  mode_code;
    logic        size_ovr;
    logic        out_valid;
    logic [63:0] out_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scaled_ea_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .base_val   (base_val),
        .index_val  (index_val),
        .index_sel  (index_sel),
        .scale_code (scale_code),
        .disp_size  (disp_size),
        .disp_raw   (disp_raw),
        .mode_code  (mode_code),
        .size_ovr   (size_ovr),
        .out_valid  (out_valid),
        .out_addr   (out_addr)
    );

    function automatic logic [63:0] model(logic [63:0] b, logic [63:0] x, logic [3:0] sel,
                                          logic [1:0] sc, logic [1:0] ds, logic [31:0] dr,
                                          logic [1:0] md, logic ov);
        int w;
        logic [63:0] m;
        logic [63:0] d;
        logic [63:0] xi;
        case (md)
            2'd0:    w = ov ? 32 : 16;
            2'd1:    w = ov ? 16 : 32;
            default: w = ov ? 32 : 64;
        endcase
        m = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        case (ds)
            2'd1:    d = {{56{dr[7]}}, dr[7:0]};
            2'd2:    d = {{32{dr[31]}}, dr};
            default: d = 64'd0;
        endcase
        xi = (sel == 4'd4) ? 64'd0 : (x << sc);
        return (b + xi + d) & m;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // called at a falling edge; result checked at the next falling edge
    task automatic issue(string req, logic [63:0] b, logic [63:0] x, logic [3:0] sel,
                         logic [1:0] sc, logic [1:0] ds, logic [31:0] dr,
                         logic [1:0] md, logic ov);
        in_valid   = 1'b1;
        base_val   = b;
        index_val  = x;
        index_sel  = sel;
        scale_code = sc;
        disp_size  = ds;
        disp_raw   = dr;
        mode_code  = md;
        size_ovr   = ov;
        @(negedge clk);
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check(req, out_addr, model(b, x, sel, sc, ds, dr, md, ov));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'h1234_5eed));
        rst_n = 1'b0; in_valid = 1'b0; base_val = '1; index_val = '1; index_sel = 0;
        scale_code = 0; disp_size = 0; disp_raw = 0; mode_code = 2; size_ovr = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset addr", out_addr, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release valid", {63'd0, out_valid}, 64'd0);
        check("R1 after release addr", out_addr, 64'd0);

        // R4 each scale code
        for (int s = 0; s < 4; s++)
            issue("R4 scale", 64'h1000, 64'h3, 4'd1, 2'(s), 2'd0, 32'd0, 2'd2, 1'b0);
        // R5 displacements
        issue("R5 byte neg", 64'h1000, 64'h0, 4'd1, 2'd0, 2'd1, 32'h0000_00F0, 2'd2, 1'b0);
        issue("R5 byte ignores upper raw", 64'h1000, 64'h0, 4'd1, 2'd0, 2'd1, 32'h7777_7705, 2'd2, 1'b0);
        issue("R5 word neg", 64'h1000, 64'h0, 4'd1, 2'd0, 2'd2, 32'hFFFF_FFF0, 2'd2, 1'b0);
        issue("R5 word pos", 64'h1000, 64'h2, 4'd3, 2'd3, 2'd2, 32'h7000_0000, 2'd2, 1'b0);
        issue("R5 code3 none", 64'h1000, 64'h0, 4'd1, 2'd0, 2'd3, 32'h0000_0055, 2'd2, 1'b0);
        // R6 no index
        issue("R6 no index", 64'h2000, 64'hDEAD_BEEF_0000_1111, 4'd4, 2'd3, 2'd1, 32'h10, 2'd2, 1'b0);
        issue("R6 sel5 used", 64'h2000, 64'h10, 4'd5, 2'd1, 2'd0, 32'h0, 2'd2, 1'b0);
        // R7 size pairs with R8 junk upper bits
        for (int md = 0; md < 4; md++)
            for (int ov = 0; ov < 2; ov++)
                issue("R7 R8 size", 64'hABCD_1234_5678_9ABC, 64'hFFFF_0000_0001_0001,
                      4'd2, 2'd2, 2'd1, 32'h80, 2'(md), 1'(ov));
        // R9 wraps
        issue("R9 wrap16", 64'h0000_0000_0000_FFAA, 64'hFF, 4'd0, 2'd0, 2'd0, 32'd0, 2'd0, 1'b0);
        issue("R9 wrap32", 64'h0000_0000_FFFF_FFFF, 64'h1, 4'd0, 2'd0, 2'd0, 32'd0, 2'd1, 1'b0);
        issue("R9 wrap64", 64'hFFFF_FFFF_FFFF_FFF0, 64'h4, 4'd0, 2'd2, 2'd0, 32'd0, 2'd2, 1'b0);

        // R3 hold, R2 drop
        held = out_addr;
        in_valid = 1'b0; base_val = 64'h5555; index_val = 64'h77; disp_size = 2'd2;
        disp_raw = 32'h1234; mode_code = 2'd2;
        @(negedge clk);
        check("R2 valid drop", {63'd0, out_valid}, 64'd0);
        check("R3 hold", out_addr, held);
        @(negedge clk);
        check("R3 hold again", out_addr, held);

        // R2 back-to-back seeded random requests
        for (int k = 0; k < 400; k++) begin
            logic [3:0] sel;
            sel = ($urandom % 4 == 0) ? 4'd4 : 4'($urandom);
            issue("R2 R4 random", {$urandom, $urandom}, {$urandom, $urandom}, sel,
                  2'($urandom), 2'($urandom), $urandom, 2'($urandom), 1'($urandom));
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 final drop", {63'd0, out_valid}, 64'd0);
        finish_run();
    end

endmodule